// File: doc/BRIEF.md
# Predicated Vector Step Sequencer

This block steps through the elements of one vectorised instruction. An instruction arrives with its address, a prefix flag, a vector length, a source and a destination predicate mask, a zeroing flag for each side, and a flag that says whether any output is a vector. The block keeps a source step and a destination step. It issues one element operation per iteration over a valid/ready handshake and waits for a completion from the execute side. Masked-out positions are passed over on each side independently, and never past the vector length.

When the loop finishes, the block writes the next-instruction address to the PC and both steps back to zero. If the executed element changed the PC or the vector state itself, the loop ends at once and the block writes neither. The steps persist between instructions, so the next instruction starts from wherever they were left. A stop request halts the block at an instruction boundary or while it waits for a completion. While halted it reports that it is stopped and passes external PC and step overrides through to the writeback ports.

Top module: `vec_step_seq`

## Requirements
- R1: After reset the block accepts an instruction (`insn_ready_o`=1). It issues no element and drives no PC write, step write, retire or stopped indication. Both steps are 0.
- R2: An instruction accepted with vector length 0 issues no element. In the accept cycle it asserts `retire_o` and `pc_we_o` with the next-instruction address.
- R3: The next-instruction address is the instruction address plus 8 when `insn_prefixed_i`=1 and plus 4 when it is 0.
- R4: With source zeroing off, a source step that is below the vector length and whose source mask bit (bit index = step) is 0 is advanced by one before issue. This repeats until the bit is 1 or the step reaches the vector length.
- R5: The destination step follows the rule of R4 using the destination mask and destination zeroing flag, independently of the source side.
- R6: With a side's zeroing flag set, that side's step is never skipped, whatever its mask bits.
- R7: Every change of the steps before issue appears on `st_we_o`, and no element is issued in that cycle or the next one (re-decode cycle).
- R8: When a completion is accepted with no change reported, and either the vector-output flag is 0 or the source step plus one is at or above the vector length, the block retires. In that cycle it writes the PC with the next-instruction address and writes both steps to 0.
- R9: If `exec_changed_i` was high in any cycle of the completion wait, including the completion cycle, the block retires with no PC write and no step write.
- R10: Otherwise, on completion both steps are written incremented by one, and the next element is issued after a re-decode cycle.
- R11: While `stop_i` is held between instructions or during a completion wait, `stopped_o`=1. The block accepts no instruction and no completion. `pc_ovr_valid_i` and `st_ovr_valid_i` are passed to the PC and step writebacks, and the override values are loaded into the steps.
- R12: The changed record is cleared when each element is issued, so an override made while stopped between instructions does not end the next instruction early.
- R13: Once `elem_valid_o` is raised, it and the issued step values hold until `elem_ready_i` accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction offered |
| insn_ready_o | output | 1 | Instruction accepted this cycle |
| insn_pc_i | input | PC_W | Instruction address |
| insn_prefixed_i | input | 1 | Instruction carries a prefix (8 bytes long) |
| insn_vl_i | input | STEP_W | Vector length |
| insn_src_mask_i | input | MAX_VL | Source predicate mask |
| insn_dst_mask_i | input | MAX_VL | Destination predicate mask |
| insn_src_zero_i | input | 1 | Source zeroing mode |
| insn_dst_zero_i | input | 1 | Destination zeroing mode |
| insn_vec_out_i | input | 1 | At least one output is a vector |
| elem_valid_o | output | 1 | Element operation offered |
| elem_ready_i | input | 1 | Execute side takes the element |
| elem_src_o | output | STEP_W | Source step of the element |
| elem_dst_o | output | STEP_W | Destination step of the element |
| cmpl_valid_i | input | 1 | Element completed |
| cmpl_ready_o | output | 1 | Completion accepted |
| exec_changed_i | input | 1 | Executed element wrote the PC or vector state |
| stop_i | input | 1 | Stop request |
| stopped_o | output | 1 | Block is halted |
| pc_ovr_valid_i | input | 1 | PC override while halted |
| pc_ovr_i | input | PC_W | PC override value |
| st_ovr_valid_i | input | 1 | Step override while halted |
| st_ovr_src_i | input | STEP_W | Source step override |
| st_ovr_dst_i | input | STEP_W | Destination step override |
| pc_we_o | output | 1 | PC write |
| pc_wdata_o | output | PC_W | PC write value |
| st_we_o | output | 1 | Step state write |
| st_src_o | output | STEP_W | Written source step |
| st_dst_o | output | STEP_W | Written destination step |
| retire_o | output | 1 | Instruction finished (one-cycle pulse) |

## Verification
The assertions assume a vector length no larger than MAX_VL and an execute side that raises a completion only after taking an element. The bench keeps every random length within 0 to MAX_VL and offers completions only after the block has entered its wait. It holds `elem_ready_i` low for random stretches so the issue hold is exercised. Overrides are driven only while `stopped_o` is high, and step overrides stay below MAX_VL so that the mask index is always defined.

// File: rtl/vss_pkg.sv
package vss_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_DECODE,
    SEQ_WAIT
  } seq_state_e;

  localparam int unsigned SIDE_SRC = 0;
  localparam int unsigned SIDE_DST = 1;
  localparam int unsigned N_SIDES  = 2;
endpackage

// File: rtl/vss_step_unit.sv
module vss_step_unit #(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned STEP_W = $clog2(MAX_VL) + 1,
  localparam int unsigned IDX_W  = $clog2(MAX_VL)
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic              zero_i,
  output logic              skip_o,
  output logic [STEP_W-1:0] inc_o,
  output logic              at_end_o
);
  logic in_range;
  logic [STEP_W:0] inc_ext;

  assign in_range = step_i < vl_i;
  // mask only consulted while in range, so index < MAX_VL
  assign skip_o   = !zero_i && in_range && !mask_i[step_i[IDX_W-1:0]];
  assign inc_ext  = {1'b0, step_i} + 1'b1;
  assign inc_o    = inc_ext[STEP_W-1:0];
  assign at_end_o = inc_ext >= {1'b0, vl_i};
endmodule

// File: rtl/vss_nia.sv
module vss_nia #(
  parameter int unsigned PC_W       = 64,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            prefixed_i,
  output logic [PC_W-1:0] nia_o
);
  localparam logic [PC_W-1:0] STEP_ONE = PC_W'(WORD_BYTES);
  localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2 * WORD_BYTES);

  assign nia_o = pc_i + (prefixed_i ? STEP_TWO : STEP_ONE);
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vss_pkg::*;
#(
  parameter int unsigned MAX_VL     = 64,
  parameter int unsigned PC_W       = 64,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned STEP_W    = $clog2(MAX_VL) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  output logic              insn_ready_o,
  input  logic [PC_W-1:0]   insn_pc_i,
  input  logic              insn_prefixed_i,
  input  logic [STEP_W-1:0] insn_vl_i,
  input  logic [MAX_VL-1:0] insn_src_mask_i,
  input  logic [MAX_VL-1:0] insn_dst_mask_i,
  input  logic              insn_src_zero_i,
  input  logic              insn_dst_zero_i,
  input  logic              insn_vec_out_i,
  output logic              elem_valid_o,
  input  logic              elem_ready_i,
  output logic [STEP_W-1:0] elem_src_o,
  output logic [STEP_W-1:0] elem_dst_o,
  input  logic              cmpl_valid_i,
  output logic              cmpl_ready_o,
  input  logic              exec_changed_i,
  input  logic              stop_i,
  output logic              stopped_o,
  input  logic              pc_ovr_valid_i,
  input  logic [PC_W-1:0]   pc_ovr_i,
  input  logic              st_ovr_valid_i,
  input  logic [STEP_W-1:0] st_ovr_src_i,
  input  logic [STEP_W-1:0] st_ovr_dst_i,
  output logic              pc_we_o,
  output logic [PC_W-1:0]   pc_wdata_o,
  output logic              st_we_o,
  output logic [STEP_W-1:0] st_src_o,
  output logic [STEP_W-1:0] st_dst_o,
  output logic              retire_o
);
  seq_state_e state_q, state_d;

  logic [STEP_W-1:0]                 vl_q;
  logic [N_SIDES-1:0][MAX_VL-1:0]    mask_q;
  logic [N_SIDES-1:0]                zero_q;
  logic [N_SIDES-1:0][STEP_W-1:0]    step_q;
  logic                              vec_out_q;
  logic [PC_W-1:0]                   nia_q;
  logic                              chg_q;

  logic [N_SIDES-1:0]                skip;
  logic [N_SIDES-1:0][STEP_W-1:0]    inc;
  logic [N_SIDES-1:0]                at_end;
  logic [PC_W-1:0]                   nia_in;
  logic                              accept;
  logic                              chg_now;
  logic                              issue_fire;

  vss_nia #(
    .PC_W      (PC_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_nia (
    .pc_i      (insn_pc_i),
    .prefixed_i(insn_prefixed_i),
    .nia_o     (nia_in)
  );

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    vss_step_unit #(
      .MAX_VL(MAX_VL)
    ) u_step (
      .step_i  (step_q[g]),
      .vl_i    (vl_q),
      .mask_i  (mask_q[g]),
      .zero_i  (zero_q[g]),
      .skip_o  (skip[g]),
      .inc_o   (inc[g]),
      .at_end_o(at_end[g])
    );
  end

  assign elem_src_o = step_q[SIDE_SRC];
  assign elem_dst_o = step_q[SIDE_DST];
  assign accept     = insn_valid_i && insn_ready_o;
  assign chg_now    = chg_q || exec_changed_i;
  assign issue_fire = elem_valid_o && elem_ready_i;

  always_comb begin
    state_d      = state_q;
    insn_ready_o = 1'b0;
    elem_valid_o = 1'b0;
    cmpl_ready_o = 1'b0;
    stopped_o    = 1'b0;
    retire_o     = 1'b0;
    pc_we_o      = 1'b0;
    pc_wdata_o   = nia_q;
    st_we_o      = 1'b0;
    st_src_o     = step_q[SIDE_SRC];
    st_dst_o     = step_q[SIDE_DST];
    unique case (state_q)
      SEQ_IDLE: begin
        if (stop_i) begin
          stopped_o = 1'b1;
        end else begin
          insn_ready_o = 1'b1;
          if (insn_valid_i) begin
            if (insn_vl_i == '0) begin
              retire_o   = 1'b1;
              pc_we_o    = 1'b1;
              pc_wdata_o = nia_in;
            end else begin
              state_d = SEQ_ISSUE;
            end
          end
        end
      end
      SEQ_ISSUE: begin
        if (|skip) begin
          st_we_o  = 1'b1;
          st_src_o = skip[SIDE_SRC] ? inc[SIDE_SRC] : step_q[SIDE_SRC];
          st_dst_o = skip[SIDE_DST] ? inc[SIDE_DST] : step_q[SIDE_DST];
          state_d  = SEQ_DECODE;
        end else begin
          elem_valid_o = 1'b1;
          if (elem_ready_i) state_d = SEQ_WAIT;
        end
      end
      SEQ_DECODE: state_d = SEQ_ISSUE;
      SEQ_WAIT: begin
        if (stop_i) begin
          stopped_o = 1'b1;
        end else begin
          cmpl_ready_o = 1'b1;
          if (cmpl_valid_i) begin
            if (chg_now) begin
              retire_o = 1'b1;
              state_d  = SEQ_IDLE;
            end else if (!vec_out_q || at_end[SIDE_SRC]) begin
              retire_o = 1'b1;
              pc_we_o  = 1'b1;
              st_we_o  = 1'b1;
              st_src_o = '0;
              st_dst_o = '0;
              state_d  = SEQ_IDLE;
            end else begin
              st_we_o  = 1'b1;
              st_src_o = inc[SIDE_SRC];
              st_dst_o = inc[SIDE_DST];
              state_d  = SEQ_DECODE;
            end
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (stopped_o) begin
      if (pc_ovr_valid_i) begin
        pc_we_o    = 1'b1;
        pc_wdata_o = pc_ovr_i;
      end
      if (st_ovr_valid_i) begin
        st_we_o  = 1'b1;
        st_src_o = st_ovr_src_i;
        st_dst_o = st_ovr_dst_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      vl_q      <= '0;
      mask_q    <= '0;
      zero_q    <= '0;
      vec_out_q <= 1'b0;
      nia_q     <= '0;
      step_q    <= '0;
      chg_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vl_q              <= insn_vl_i;
        mask_q[SIDE_SRC]  <= insn_src_mask_i;
        mask_q[SIDE_DST]  <= insn_dst_mask_i;
        zero_q[SIDE_SRC]  <= insn_src_zero_i;
        zero_q[SIDE_DST]  <= insn_dst_zero_i;
        vec_out_q         <= insn_vec_out_i;
        nia_q             <= nia_in;
      end
      if (st_we_o) begin
        step_q[SIDE_SRC] <= st_src_o;
        step_q[SIDE_DST] <= st_dst_o;
      end
      if (issue_fire) begin
        chg_q <= 1'b0;
      end else if ((stopped_o && (pc_ovr_valid_i || st_ovr_valid_i)) ||
                   (state_q == SEQ_WAIT && exec_changed_i)) begin
        chg_q <= 1'b1;
      end
    end
  end

  // R13
  elem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o && !elem_ready_i |=> elem_valid_o && $stable(elem_src_o) && $stable(elem_dst_o));

  // R7
  redecode_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_o && !stopped_o |=> !elem_valid_o);

  // R11
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> !elem_valid_o && !insn_ready_o && !cmpl_ready_o && !retire_o);

  // R8
  pc_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o && !stopped_o |-> retire_o);

  // R2
  vl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i && insn_ready_o && insn_vl_i == '0 |-> retire_o && pc_we_o && !elem_valid_o);

  // R9
  retire_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !elem_valid_o && !cmpl_ready_o);
endmodule

// File: tb/tb_vec_step_seq.sv
module tb_vec_step_seq;
  localparam int unsigned MAX_VL = 64;
  localparam int unsigned PC_W   = 64;
  localparam int unsigned STEP_W = $clog2(MAX_VL) + 1;
  localparam time CLK_PERIOD     = 10ns;
  localparam int  WATCHDOG       = 150000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              insn_valid_i = 1'b0;
  logic              insn_ready_o;
  logic [PC_W-1:0]   insn_pc_i = '0;
  logic              insn_prefixed_i = 1'b0;
  logic [STEP_W-1:0] insn_vl_i = '0;
  logic [MAX_VL-1:0] insn_src_mask_i = '0;
  logic [MAX_VL-1:0] insn_dst_mask_i = '0;
  logic              insn_src_zero_i = 1'b0;
  logic              insn_dst_zero_i = 1'b0;
  logic              insn_vec_out_i = 1'b0;
  logic              elem_valid_o;
  logic              elem_ready_i = 1'b0;
  logic [STEP_W-1:0] elem_src_o;
  logic [STEP_W-1:0] elem_dst_o;
  logic              cmpl_valid_i = 1'b0;
  logic              cmpl_ready_o;
  logic              exec_changed_i = 1'b0;
  logic              stop_i = 1'b0;
  logic              stopped_o;
  logic              pc_ovr_valid_i = 1'b0;
  logic [PC_W-1:0]   pc_ovr_i = '0;
  logic              st_ovr_valid_i = 1'b0;
  logic [STEP_W-1:0] st_ovr_src_i = '0;
  logic [STEP_W-1:0] st_ovr_dst_i = '0;
  logic              pc_we_o;
  logic [PC_W-1:0]   pc_wdata_o;
  logic              st_we_o;
  logic [STEP_W-1:0] st_src_o;
  logic [STEP_W-1:0] st_dst_o;
  logic              retire_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ms = 0;
  int md = 0;
  int n_el = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_step_seq #(.MAX_VL(MAX_VL), .PC_W(PC_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .insn_valid_i(insn_valid_i), .insn_ready_o(insn_ready_o),
    .insn_pc_i(insn_pc_i), .insn_prefixed_i(insn_prefixed_i),
    .insn_vl_i(insn_vl_i), .insn_src_mask_i(insn_src_mask_i),
    .insn_dst_mask_i(insn_dst_mask_i), .insn_src_zero_i(insn_src_zero_i),
    .insn_dst_zero_i(insn_dst_zero_i), .insn_vec_out_i(insn_vec_out_i),
    .elem_valid_o(elem_valid_o), .elem_ready_i(elem_ready_i),
    .elem_src_o(elem_src_o), .elem_dst_o(elem_dst_o),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_ready_o(cmpl_ready_o),
    .exec_changed_i(exec_changed_i), .stop_i(stop_i), .stopped_o(stopped_o),
    .pc_ovr_valid_i(pc_ovr_valid_i), .pc_ovr_i(pc_ovr_i),
    .st_ovr_valid_i(st_ovr_valid_i), .st_ovr_src_i(st_ovr_src_i),
    .st_ovr_dst_i(st_ovr_dst_i), .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o),
    .st_we_o(st_we_o), .st_src_o(st_src_o), .st_dst_o(st_dst_o),
    .retire_o(retire_o)
  );

  function automatic logic [PC_W-1:0] exp_nia(input logic [PC_W-1:0] pc, input bit pref);
    return pc + (pref ? 64'd8 : 64'd4);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // drive one instruction and follow its loop against the bench model
  task automatic run_insn(input logic [PC_W-1:0] pc, input bit pref, input int vl,
                          input logic [MAX_VL-1:0] sm, input logic [MAX_VL-1:0] dm,
                          input bit sz, input bit dz, input bit lc,
                          input int chg_el, input bit stop_el0);
    logic [PC_W-1:0] nia = exp_nia(pc, pref);
    int el = 0;
    n_el = 0;
    @(negedge clk);
    insn_valid_i = 1'b1; insn_pc_i = pc; insn_prefixed_i = pref;
    insn_vl_i = STEP_W'(vl); insn_src_mask_i = sm; insn_dst_mask_i = dm;
    insn_src_zero_i = sz; insn_dst_zero_i = dz; insn_vec_out_i = lc;
    #1;
    chk(insn_ready_o, "R1 ready between instructions", insn_ready_o, 1);
    if (vl == 0) begin
      chk(retire_o && pc_we_o && !elem_valid_o, "R2 vl zero retire",
          {retire_o, pc_we_o, elem_valid_o}, 3'b110);
      chk(pc_wdata_o == nia, "R3 next address on vl zero", pc_wdata_o, nia);
      @(negedge clk);
      insn_valid_i = 1'b0;
      return;
    end
    chk(!retire_o && !pc_we_o, "R2 no retire when vl nonzero", {retire_o, pc_we_o}, 0);
    @(negedge clk);
    insn_valid_i = 1'b0;
    forever begin
      bit skipped = 0;
      bit saw_st = 0;
      bit prev_st = 0;
      bit is_chg;
      int n = 0;
      // model skip phase (R4 R5 R6)
      forever begin
        bit ss = !sz && ms < vl && !sm[ms];
        bit ds = !dz && md < vl && !dm[md];
        if (!ss && !ds) break;
        ms += int'(ss);
        md += int'(ds);
        skipped = 1;
      end
      forever begin
        #1;
        if (elem_valid_o) break;
        prev_st = st_we_o;
        if (st_we_o) saw_st = 1;
        @(negedge clk);
        n++;
        if (n > 300) begin
          chk(0, "R4 element issue timeout", n, 0);
          return;
        end
      end
      chk(!prev_st, "R7 re-decode cycle before issue", prev_st, 0);
      if (skipped) chk(saw_st, "R7 skip written to state", saw_st, 1);
      chk(elem_src_o == STEP_W'(ms), sz ? "R6 source step zeroing" : "R4 source step",
          elem_src_o, ms);
      chk(elem_dst_o == STEP_W'(md), dz ? "R6 dest step zeroing" : "R5 dest step",
          elem_dst_o, md);
      repeat ($urandom % 3) begin
        @(negedge clk); #1;
        chk(elem_valid_o && elem_src_o == STEP_W'(ms) && elem_dst_o == STEP_W'(md),
            "R13 element held", {elem_valid_o, elem_src_o, elem_dst_o}, {1'b1, 7'(ms), 7'(md)});
      end
      elem_ready_i = 1'b1;
      @(negedge clk);
      elem_ready_i = 1'b0;
      n_el++;
      if (stop_el0 && el == 0) begin
        stop_i = 1'b1; cmpl_valid_i = 1'b1;
        #1;
        chk(stopped_o && !cmpl_ready_o, "R11 stop in wait", {stopped_o, cmpl_ready_o}, 2'b10);
        st_ovr_valid_i = 1'b1; st_ovr_src_i = 7'd1; st_ovr_dst_i = 7'd2;
        #1;
        chk(st_we_o && st_src_o == 7'd1 && st_dst_o == 7'd2, "R11 step override in wait",
            {st_we_o, st_src_o, st_dst_o}, {1'b1, 7'd1, 7'd2});
        @(negedge clk);
        st_ovr_valid_i = 1'b0; stop_i = 1'b0;
        ms = 1; md = 2;
        #1;
        chk(cmpl_ready_o && retire_o && !pc_we_o && !st_we_o, "R9 override counts as change",
            {cmpl_ready_o, retire_o, pc_we_o, st_we_o}, 4'b1100);
        @(negedge clk);
        cmpl_valid_i = 1'b0;
        return;
      end
      is_chg = (el == chg_el);
      exec_changed_i = is_chg;
      repeat ($urandom % 3) begin
        @(negedge clk);
        exec_changed_i = 1'b0;
      end
      cmpl_valid_i = 1'b1;
      #1;
      chk(cmpl_ready_o, "R10 completion accepted", cmpl_ready_o, 1);
      if (is_chg) begin
        chk(retire_o && !pc_we_o && !st_we_o, "R9 changed exit",
            {retire_o, pc_we_o, st_we_o}, 3'b100);
      end else if (!lc || ms + 1 >= vl) begin
        chk(retire_o && pc_we_o && pc_wdata_o == nia, "R8 loop end pc write",
            {retire_o, pc_we_o, pc_wdata_o}, {2'b11, nia});
        chk(st_we_o && st_src_o == 0 && st_dst_o == 0, "R8 steps reset",
            {st_we_o, st_src_o, st_dst_o}, {1'b1, 14'd0});
        ms = 0; md = 0;
      end else begin
        chk(!retire_o && !pc_we_o && st_we_o && st_src_o == STEP_W'(ms + 1) &&
            st_dst_o == STEP_W'(md + 1), "R10 step increment",
            {retire_o, pc_we_o, st_we_o, st_src_o, st_dst_o},
            {3'b001, 7'(ms + 1), 7'(md + 1)});
        ms++; md++;
      end
      @(negedge clk);
      cmpl_valid_i = 1'b0;
      exec_changed_i = 1'b0;
      if (retire_o || is_chg || !lc || ms == 0) begin
        if (is_chg || ms == 0 || !lc) return;
      end
      el++;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(insn_ready_o && !elem_valid_o && !pc_we_o && !st_we_o && !retire_o && !stopped_o,
        "R1 reset outputs", {insn_ready_o, elem_valid_o, pc_we_o, st_we_o, retire_o, stopped_o},
        6'b100000);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(insn_ready_o && !elem_valid_o && !stopped_o, "R1 idle after reset",
        {insn_ready_o, elem_valid_o, stopped_o}, 3'b100);

    // R2 R3 zero length, both sizes
    run_insn(64'h1000, 1'b1, 0, '1, '1, 0, 0, 1, -1, 0);
    run_insn(64'h2000, 1'b0, 0, '1, '1, 0, 0, 1, -1, 0);
    // full loop, all enabled (first element at steps 0 confirms R1)
    run_insn(64'h3000, 1'b0, 5, '1, '1, 0, 0, 1, -1, 0);
    // no vector output: single element (R8)
    run_insn(64'h3004, 1'b1, 5, '1, '1, 0, 0, 0, -1, 0);
    // independent skipping (R4 R5)
    run_insn(64'h4000, 1'b0, 8, 64'b1010_0100, 64'b0111_1000, 0, 0, 1, -1, 0);
    // all masked: steps bounded by VL
    run_insn(64'h4100, 1'b0, 6, '0, 64'h3f, 0, 0, 1, -1, 0);
    // zeroing disables skip (R6)
    run_insn(64'h5000, 1'b1, 4, '0, '0, 1, 1, 1, -1, 0);
    // change reported on second element (R9)
    run_insn(64'h6000, 1'b0, 6, '1, '1, 0, 0, 1, 1, 0);
    // next instruction resumes from the left steps
    run_insn(64'h6100, 1'b0, 6, '1, '1, 0, 0, 1, -1, 0);

    // R11 stop between instructions with overrides
    @(negedge clk);
    stop_i = 1'b1; insn_valid_i = 1'b1; insn_vl_i = 7'd3;
    #1;
    chk(stopped_o && !insn_ready_o, "R11 stopped in idle", {stopped_o, insn_ready_o}, 2'b10);
    pc_ovr_valid_i = 1'b1; pc_ovr_i = 64'hdead_0000;
    #1;
    chk(pc_we_o && pc_wdata_o == 64'hdead_0000, "R11 pc override", pc_wdata_o, 64'hdead_0000);
    @(negedge clk);
    pc_ovr_valid_i = 1'b0; insn_valid_i = 1'b0;
    st_ovr_valid_i = 1'b1; st_ovr_src_i = 7'd3; st_ovr_dst_i = 7'd3;
    #1;
    chk(st_we_o && st_src_o == 7'd3, "R11 step override", st_src_o, 3);
    @(negedge clk);
    st_ovr_valid_i = 1'b0; stop_i = 1'b0;
    ms = 3; md = 3;
    // R12 override-set change record is cleared at issue: loop runs 3..9
    run_insn(64'h7000, 1'b0, 10, '1, '1, 0, 0, 1, -1, 0);
    chk(n_el == 7, "R12 change record cleared at issue", n_el, 7);
    // stop while waiting for completion
    run_insn(64'h7100, 1'b0, 10, '1, '1, 0, 0, 1, -1, 1);

    // constrained random
    for (int i = 0; i < 150; i++) begin
      int vl = ($urandom % 4 == 0) ? int'($urandom % (MAX_VL + 1)) : int'($urandom % 12);
      logic [MAX_VL-1:0] sm = {$urandom, $urandom} | {$urandom, $urandom};
      logic [MAX_VL-1:0] dm = {$urandom, $urandom} & {$urandom, $urandom} | {$urandom, $urandom};
      int chg = ($urandom % 5 == 0) ? int'($urandom % 4) : -1;
      run_insn({$urandom, $urandom} & ~64'h3, 1'($urandom), vl, sm, dm,
               ($urandom % 6 == 0), ($urandom % 6 == 0), ($urandom % 5 != 0), chg, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule